// File: doc/BRIEF.md
# Keyboard-Driven Settings Overlay Controller

This block runs a small settings menu entirely in hardware, steered only by keyboard scancodes. A scancode byte stream (PS/2 set 2, already deserialized) enters on one port. The block turns it into key events and decides where each event goes. An event can drive the menu, the emulated joystick, or the forwarded keyboard stream of the emulated machine. No processor or firmware is involved, and the menu runs whether or not the emulated machine is doing anything.

The menu holds four settings: the selected floppy image, floppy write protection, arrow-key joystick emulation, and the selected ROM image. The floppy and ROM entries open a list whose length comes from an input port. While the overlay is visible, the block repaints a text window of four rows by `COLS` columns through a character-cell write port, one cell per cycle. Font rendering and pixel mixing are done elsewhere.

Top module: `kbd_menu_ctrl`

## Requirements
- R1: After reset the overlay is hidden, write protection is on, joystick emulation is off, both image indices are zero, all joystick directions are low and no strobe, forward or cell write is active.
- R2: The make code of Home (E0 6C) toggles the overlay between hidden and shown. The Home break (E0 F0 6C) changes nothing and is never forwarded. Showing the overlay opens the top menu with the cursor on entry 0.
- R3: Byte E0 marks the next code as extended and byte F0 marks it as a release. A code is recognised as a menu key only when it is extended. A plain 6C, for example, is an ordinary key and is forwarded with ext=0 and brk=0.
- R4: In the top menu, Down (E0 72) and Up (E0 75) move the cursor over four entries: 0 floppy list, 1 write protection, 2 joystick emulation, 3 ROM list. The cursor wraps past either end. Release codes do not move it.
- R5: Right CTRL (E0 14) confirms the entry under the cursor. On entry 1 it inverts write protection, and on entry 2 it inverts joystick emulation.
- R6: Confirming entry 0 or 3 opens the floppy or ROM list with its cursor at 0. Up and Down wrap within the item count on `floppy_count` or `rom_count`. With a count of zero the cursor stays put and confirm does nothing.
- R7: Confirming a list item copies its index to `floppy_idx` or `rom_idx`, raises `floppy_load` or `rom_load` for exactly one cycle, and returns to the top menu with the top cursor unchanged.
- R8: Left (E0 6B) inside a list returns to the top menu and changes no index, flag or strobe.
- R9: While the overlay is shown, no key event is forwarded and all joystick direction outputs are low.
- R10: With the overlay hidden and joystick emulation on, an arrow make raises its direction output and its release lowers it: up, down, left or right. Arrow events are then not forwarded, and every other non-Home event is forwarded.
- R11: With the overlay hidden and joystick emulation off, arrow events are forwarded like any other key, with their code, extended flag and release flag.
- R12: Each shown-menu make event, and each showing of the overlay, starts a repaint of all 4*COLS cells at address row*COLS+col. Column 0 holds '>' on the cursor row and ' ' on the other rows. In the top menu, columns 1 to 7 hold the entry names FLOPPY, WPROT, JOYST and ROM, and column 8 on rows 1 and 2 holds 'Y' or 'N' for the flag. In a list view, row r shows item 4*(cursor/4)+r as two upper-case hex digits in columns 1 and 2, or blanks when that item is past the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kb_valid | input | 1 | Scancode byte valid |
| kb_byte | input | 8 | Scancode byte |
| floppy_count | input | IDX_W | Number of floppy images |
| rom_count | input | IDX_W | Number of ROM images |
| osd_shown | output | 1 | Overlay visible |
| cell_we | output | 1 | Character cell write enable |
| cell_addr | output | CELL_AW | Cell address, row*COLS+col |
| cell_char | output | 8 | ASCII character for the cell |
| floppy_idx | output | IDX_W | Selected floppy image |
| floppy_load | output | 1 | One-cycle floppy selection strobe |
| rom_idx | output | IDX_W | Selected ROM image |
| rom_load | output | 1 | One-cycle ROM selection strobe |
| wp_on | output | 1 | Floppy write protection |
| joy_en | output | 1 | Arrow-key joystick emulation enabled |
| joy_up | output | 1 | Emulated joystick up |
| joy_down | output | 1 | Emulated joystick down |
| joy_left | output | 1 | Emulated joystick left |
| joy_right | output | 1 | Emulated joystick right |
| key_valid | output | 1 | Forwarded key event valid |
| key_code | output | 8 | Forwarded key code |
| key_ext | output | 1 | Forwarded event carried the E0 prefix |
| key_brk | output | 1 | Forwarded event carried the F0 prefix |

## Verification
The hardest state to reach is a list view whose cursor sits past the first group of four items. Only there does the repaint show a non-zero row base with blank rows beyond the count. Getting there takes a show, a confirm on entry 0 and an Up that wraps to the last item. The empty-list case is just as deep: it needs the ROM count tied to zero, an Up from entry 0 that wraps to entry 3, then a confirm. The stimulus table walks one long cumulative sequence through both menus, both flag toggles and a joystick session. The directed tests then reach these two states from a fresh reset and read the resulting screen back through a shadow copy built from the cell writes.

// File: rtl/kmc_pkg.sv
package kmc_pkg;

  typedef enum logic [2:0] {
    K_OTHER, K_HOME, K_RCTRL, K_UP, K_DOWN, K_LEFT, K_RIGHT
  } key_e;

  typedef struct packed {
    logic       brk;
    logic       ext;
    logic [7:0] code;
    key_e       key;
  } kev_t;

  typedef enum logic [1:0] {
    V_TOP, V_FLOPPY, V_ROM
  } view_e;

  localparam logic [7:0] SC_EXT = 8'hE0;
  localparam logic [7:0] SC_BRK = 8'hF0;

  localparam logic [1:0] ENT_FLOPPY = 2'd0;
  localparam logic [1:0] ENT_WPROT  = 2'd1;
  localparam logic [1:0] ENT_JOY    = 2'd2;
  localparam logic [1:0] ENT_ROM    = 2'd3;

  localparam int MENU_ROWS = 4;

  function automatic key_e classify(input logic ext, input logic [7:0] b);
    key_e k;
    k = K_OTHER;
    if (ext) begin
      case (b)
        8'h6C:   k = K_HOME;
        8'h14:   k = K_RCTRL;
        8'h75:   k = K_UP;
        8'h72:   k = K_DOWN;
        8'h6B:   k = K_LEFT;
        8'h74:   k = K_RIGHT;
        default: k = K_OTHER;
      endcase
    end
    return k;
  endfunction

  function automatic logic [7:0] hex_char(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

endpackage

// File: rtl/kmc_scan_decode.sv
module kmc_scan_decode
  import kmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       kb_valid,
  input  logic [7:0] kb_byte,
  output logic       ev_valid,
  output kev_t       ev
);

  logic ext_q;
  logic brk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q    <= 1'b0;
      brk_q    <= 1'b0;
      ev_valid <= 1'b0;
      ev       <= '0;
    end else begin
      ev_valid <= 1'b0;
      if (kb_valid) begin
        if (kb_byte == SC_EXT) begin
          ext_q <= 1'b1;
        end else if (kb_byte == SC_BRK) begin
          brk_q <= 1'b1;
        end else begin
          ev_valid <= 1'b1;
          ev.code  <= kb_byte;
          ev.ext   <= ext_q;
          ev.brk   <= brk_q;
          ev.key   <= classify(ext_q, kb_byte);
          ext_q    <= 1'b0;
          brk_q    <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/kmc_menu_fsm.sv
module kmc_menu_fsm
  import kmc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  kev_t             ev,
  input  logic [IDX_W-1:0] floppy_count,
  input  logic [IDX_W-1:0] rom_count,
  output logic             shown,
  output view_e            view,
  output logic [1:0]       top_cur,
  output logic [IDX_W-1:0] sub_cur,
  output logic             wp_on,
  output logic             joy_en,
  output logic [IDX_W-1:0] floppy_idx,
  output logic [IDX_W-1:0] rom_idx,
  output logic             floppy_load,
  output logic             rom_load,
  output logic [3:0]       joy_dirs,
  output logic             fwd_valid,
  output logic [7:0]       fwd_code,
  output logic             fwd_ext,
  output logic             fwd_brk,
  output logic             redraw
);

  logic             n_shown, n_wp, n_joy, n_fl_ld, n_rm_ld, n_fwd, n_redraw;
  view_e            n_view;
  logic [1:0]       n_top;
  logic [IDX_W-1:0] n_sub, n_fidx, n_ridx, lim;
  logic [3:0]       n_dirs;
  logic             is_arrow;
  logic [1:0]       arrow_bit;

  always_comb begin
    is_arrow  = 1'b1;
    arrow_bit = 2'd0;
    case (ev.key)
      K_UP:    arrow_bit = 2'd3;
      K_DOWN:  arrow_bit = 2'd2;
      K_LEFT:  arrow_bit = 2'd1;
      K_RIGHT: arrow_bit = 2'd0;
      default: is_arrow  = 1'b0;
    endcase
  end

  always_comb begin
    n_shown  = shown;
    n_view   = view;
    n_top    = top_cur;
    n_sub    = sub_cur;
    n_wp     = wp_on;
    n_joy    = joy_en;
    n_fidx   = floppy_idx;
    n_ridx   = rom_idx;
    n_fl_ld  = 1'b0;
    n_rm_ld  = 1'b0;
    n_fwd    = 1'b0;
    n_redraw = 1'b0;
    n_dirs   = joy_dirs;
    lim      = (view == V_FLOPPY) ? floppy_count : rom_count;
    if (ev_valid) begin
      if (ev.key == K_HOME) begin
        if (!ev.brk) begin
          n_shown  = !shown;
          n_view   = V_TOP;
          n_top    = 2'd0;
          n_redraw = !shown;
        end
      end else if (shown) begin
        if (!ev.brk) begin
          n_redraw = 1'b1;
          if (view == V_TOP) begin
            case (ev.key)
              K_UP:   n_top = top_cur - 2'd1;
              K_DOWN: n_top = top_cur + 2'd1;
              K_RCTRL: begin
                case (top_cur)
                  ENT_FLOPPY: begin n_view = V_FLOPPY; n_sub = '0; end
                  ENT_WPROT:  n_wp  = !wp_on;
                  ENT_JOY:    n_joy = !joy_en;
                  default:    begin n_view = V_ROM; n_sub = '0; end
                endcase
              end
              default: ;
            endcase
          end else begin
            case (ev.key)
              K_UP: if (lim != '0)
                n_sub = (sub_cur == '0) ? lim - 1'b1 : sub_cur - 1'b1;
              K_DOWN: if (lim != '0)
                n_sub = (sub_cur >= lim - 1'b1) ? '0 : sub_cur + 1'b1;
              K_LEFT: n_view = V_TOP;
              K_RCTRL: if (lim != '0 && sub_cur < lim) begin
                if (view == V_FLOPPY) begin
                  n_fidx  = sub_cur;
                  n_fl_ld = 1'b1;
                end else begin
                  n_ridx  = sub_cur;
                  n_rm_ld = 1'b1;
                end
                n_view = V_TOP;
              end
              default: ;
            endcase
          end
        end
      end else if (joy_en && is_arrow) begin
        n_dirs[arrow_bit] = !ev.brk;
      end else begin
        n_fwd = 1'b1;
      end
    end
    if (n_shown || !n_joy) n_dirs = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shown       <= 1'b0;
      view        <= V_TOP;
      top_cur     <= 2'd0;
      sub_cur     <= '0;
      wp_on       <= 1'b1;
      joy_en      <= 1'b0;
      floppy_idx  <= '0;
      rom_idx     <= '0;
      floppy_load <= 1'b0;
      rom_load    <= 1'b0;
      joy_dirs    <= '0;
      fwd_valid   <= 1'b0;
      fwd_code    <= '0;
      fwd_ext     <= 1'b0;
      fwd_brk     <= 1'b0;
      redraw      <= 1'b0;
    end else begin
      shown       <= n_shown;
      view        <= n_view;
      top_cur     <= n_top;
      sub_cur     <= n_sub;
      wp_on       <= n_wp;
      joy_en      <= n_joy;
      floppy_idx  <= n_fidx;
      rom_idx     <= n_ridx;
      floppy_load <= n_fl_ld;
      rom_load    <= n_rm_ld;
      joy_dirs    <= n_dirs;
      fwd_valid   <= n_fwd;
      redraw      <= n_redraw;
      if (n_fwd) begin
        fwd_code <= ev.code;
        fwd_ext  <= ev.ext;
        fwd_brk  <= ev.brk;
      end
    end
  end

endmodule

// File: rtl/kmc_text_writer.sv
module kmc_text_writer
  import kmc_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int COLS  = 12,
  localparam int CELLS = MENU_ROWS * COLS,
  localparam int AW    = $clog2(CELLS),
  localparam int CW    = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             redraw,
  input  view_e            view,
  input  logic [1:0]       top_cur,
  input  logic [IDX_W-1:0] sub_cur,
  input  logic             wp_on,
  input  logic             joy_en,
  input  logic [IDX_W-1:0] floppy_count,
  input  logic [IDX_W-1:0] rom_count,
  output logic             cell_we,
  output logic [AW-1:0]    cell_addr,
  output logic [7:0]       cell_char
);

  logic             busy;
  logic [1:0]       row;
  logic [CW-1:0]    col;
  logic [7:0]       ch;
  logic [55:0]      lbl;
  logic [IDX_W-1:0] item, lim;
  logic [7:0]       item8;
  logic             flag;

  always_comb begin
    case (row)
      2'd0:    lbl = "FLOPPY ";
      2'd1:    lbl = "WPROT  ";
      2'd2:    lbl = "JOYST  ";
      default: lbl = "ROM    ";
    endcase
    flag  = (row == ENT_WPROT) ? wp_on : joy_en;
    item  = {sub_cur[IDX_W-1:2], row};
    item8 = 8'(item);
    lim   = (view == V_FLOPPY) ? floppy_count : rom_count;
    ch    = " ";
    if (view == V_TOP) begin
      if (col == '0)
        ch = (row == top_cur) ? ">" : " ";
      else if (int'(col) <= 7)
        ch = lbl[8*(7-int'(col)) +: 8];
      else if (int'(col) == 8 && (row == ENT_WPROT || row == ENT_JOY))
        ch = flag ? "Y" : "N";
    end else begin
      if (col == '0)
        ch = (row == sub_cur[1:0]) ? ">" : " ";
      else if (item < lim && int'(col) == 1)
        ch = hex_char(item8[7:4]);
      else if (item < lim && int'(col) == 2)
        ch = hex_char(item8[3:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      row       <= 2'd0;
      col       <= '0;
      cell_we   <= 1'b0;
      cell_addr <= '0;
      cell_char <= '0;
    end else if (redraw) begin
      busy    <= 1'b1;
      row     <= 2'd0;
      col     <= '0;
      cell_we <= 1'b0;
    end else if (busy) begin
      cell_we   <= 1'b1;
      cell_addr <= AW'(int'(row) * COLS + int'(col));
      cell_char <= ch;
      if (int'(col) == COLS - 1) begin
        col <= '0;
        row <= row + 2'd1;
        if (row == 2'(MENU_ROWS - 1)) busy <= 1'b0;
      end else begin
        col <= col + 1'b1;
      end
    end else begin
      cell_we <= 1'b0;
    end
  end

endmodule

// File: rtl/kbd_menu_ctrl.sv
module kbd_menu_ctrl
  import kmc_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int COLS  = 12,
  localparam int CELL_AW = $clog2(MENU_ROWS * COLS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               kb_valid,
  input  logic [7:0]         kb_byte,
  input  logic [IDX_W-1:0]   floppy_count,
  input  logic [IDX_W-1:0]   rom_count,
  output logic               osd_shown,
  output logic               cell_we,
  output logic [CELL_AW-1:0] cell_addr,
  output logic [7:0]         cell_char,
  output logic [IDX_W-1:0]   floppy_idx,
  output logic               floppy_load,
  output logic [IDX_W-1:0]   rom_idx,
  output logic               rom_load,
  output logic               wp_on,
  output logic               joy_en,
  output logic               joy_up,
  output logic               joy_down,
  output logic               joy_left,
  output logic               joy_right,
  output logic               key_valid,
  output logic [7:0]         key_code,
  output logic               key_ext,
  output logic               key_brk
);

  logic             ev_valid;
  kev_t             ev;
  view_e            view;
  logic [1:0]       top_cur;
  logic [IDX_W-1:0] sub_cur;
  logic [3:0]       joy_dirs;
  logic             redraw;

  kmc_scan_decode u_dec (
    .clk      (clk),
    .rst      (rst),
    .kb_valid (kb_valid),
    .kb_byte  (kb_byte),
    .ev_valid (ev_valid),
    .ev       (ev)
  );

  kmc_menu_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .ev_valid     (ev_valid),
    .ev           (ev),
    .floppy_count (floppy_count),
    .rom_count    (rom_count),
    .shown        (osd_shown),
    .view         (view),
    .top_cur      (top_cur),
    .sub_cur      (sub_cur),
    .wp_on        (wp_on),
    .joy_en       (joy_en),
    .floppy_idx   (floppy_idx),
    .rom_idx      (rom_idx),
    .floppy_load  (floppy_load),
    .rom_load     (rom_load),
    .joy_dirs     (joy_dirs),
    .fwd_valid    (key_valid),
    .fwd_code     (key_code),
    .fwd_ext      (key_ext),
    .fwd_brk      (key_brk),
    .redraw       (redraw)
  );

  kmc_text_writer #(.IDX_W(IDX_W), .COLS(COLS)) u_txt (
    .clk          (clk),
    .rst          (rst),
    .redraw       (redraw),
    .view         (view),
    .top_cur      (top_cur),
    .sub_cur      (sub_cur),
    .wp_on        (wp_on),
    .joy_en       (joy_en),
    .floppy_count (floppy_count),
    .rom_count    (rom_count),
    .cell_we      (cell_we),
    .cell_addr    (cell_addr),
    .cell_char    (cell_char)
  );

  assign joy_up    = joy_dirs[3];
  assign joy_down  = joy_dirs[2];
  assign joy_left  = joy_dirs[1];
  assign joy_right = joy_dirs[0];

endmodule

// File: rtl/kmc_checker.sv
module kmc_checker #(
  parameter int IDX_W   = 6,
  parameter int COLS    = 12,
  parameter int CELL_AW = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               osd_shown,
  input logic               cell_we,
  input logic [CELL_AW-1:0] cell_addr,
  input logic               floppy_load,
  input logic               rom_load,
  input logic [IDX_W-1:0]   floppy_idx,
  input logic [IDX_W-1:0]   rom_idx,
  input logic               wp_on,
  input logic               joy_en,
  input logic               joy_up,
  input logic               joy_down,
  input logic               joy_left,
  input logic               joy_right,
  input logic               key_valid
);

  p_fload_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    floppy_load |=> !floppy_load);

  p_rload_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rom_load |=> !rom_load);

  p_fidx_only_on_load_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(floppy_idx) |-> floppy_load);

  p_ridx_only_on_load_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(rom_idx) |-> rom_load);

  p_flags_change_shown_r5: assert property (@(posedge clk) disable iff (rst)
    (!$stable(wp_on) || !$stable(joy_en)) |-> (osd_shown && $past(osd_shown)));

  p_no_fwd_shown_r9: assert property (@(posedge clk) disable iff (rst)
    osd_shown |-> !key_valid);

  p_joy_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (osd_shown || !joy_en) |-> !(joy_up || joy_down || joy_left || joy_right));

  p_cell_in_range_r12: assert property (@(posedge clk) disable iff (rst)
    cell_we |-> (int'(cell_addr) < 4 * COLS));

endmodule

bind kbd_menu_ctrl kmc_checker #(.IDX_W(IDX_W), .COLS(COLS), .CELL_AW(CELL_AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .osd_shown   (osd_shown),
  .cell_we     (cell_we),
  .cell_addr   (cell_addr),
  .floppy_load (floppy_load),
  .rom_load    (rom_load),
  .floppy_idx  (floppy_idx),
  .rom_idx     (rom_idx),
  .wp_on       (wp_on),
  .joy_en      (joy_en),
  .joy_up      (joy_up),
  .joy_down    (joy_down),
  .joy_left    (joy_left),
  .joy_right   (joy_right),
  .key_valid   (key_valid)
);

// File: tb/kbd_menu_ctrl_test.sv
module kbd_menu_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 6;
  localparam int COLS  = 12;
  localparam int CELLS = 4 * COLS;
  localparam int AW    = $clog2(CELLS);
  localparam int NV    = 34;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             kb_valid = 1'b0;
  logic [7:0]       kb_byte = 8'h00;
  logic [IDX_W-1:0] floppy_count = 6'd5;
  logic [IDX_W-1:0] rom_count = 6'd3;
  logic             osd_shown, cell_we, floppy_load, rom_load, wp_on, joy_en;
  logic [AW-1:0]    cell_addr;
  logic [7:0]       cell_char, key_code;
  logic [IDX_W-1:0] floppy_idx, rom_idx;
  logic             joy_up, joy_down, joy_left, joy_right, key_valid, key_ext, key_brk;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_menu_ctrl #(.IDX_W(IDX_W), .COLS(COLS)) uut (
    .clk(clk), .rst(rst), .kb_valid(kb_valid), .kb_byte(kb_byte),
    .floppy_count(floppy_count), .rom_count(rom_count),
    .osd_shown(osd_shown), .cell_we(cell_we), .cell_addr(cell_addr),
    .cell_char(cell_char), .floppy_idx(floppy_idx), .floppy_load(floppy_load),
    .rom_idx(rom_idx), .rom_load(rom_load), .wp_on(wp_on), .joy_en(joy_en),
    .joy_up(joy_up), .joy_down(joy_down), .joy_left(joy_left),
    .joy_right(joy_right), .key_valid(key_valid), .key_code(key_code),
    .key_ext(key_ext), .key_brk(key_brk)
  );

  int n_run = 0;
  int n_fail = 0;
  int fs_cnt = 0, rs_cnt = 0, fw_cnt = 0, we_cnt = 0;
  logic [7:0] last_code;
  logic       last_ext, last_brk;
  logic [7:0] shadow [CELLS];

  always @(negedge clk) begin
    if (!rst) begin
      if (floppy_load) fs_cnt++;
      if (rom_load) rs_cnt++;
      if (key_valid) begin
        fw_cnt++;
        last_code = key_code;
        last_ext  = key_ext;
        last_brk  = key_brk;
      end
      if (cell_we) begin
        we_cnt++;
        shadow[int'(cell_addr)] = cell_char;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    kb_valid = 1'b1;
    kb_byte  = b;
    @(negedge clk);
    kb_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  task automatic key_ext_make(input logic [7:0] c);
    put(8'hE0); put(c); settle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    fs_cnt = 0; rs_cnt = 0; fw_cnt = 0; we_cnt = 0;
    for (int i = 0; i < CELLS; i++) shadow[i] = 8'h00;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0] b0; logic [7:0] b1; logic [7:0] b2; logic [1:0] nb;
    logic sh; logic wp; logic jy;
    logic [5:0] fi; logic [5:0] ri; logic [3:0] dr;
    logic [3:0] fs; logic [3:0] rs; logic [7:0] fw; logic [2:0] mr;
  } vec_t;

  // Cumulative sequence with floppy_count=5, rom_count=3. mr=4 means no screen check.
  localparam vec_t VEC [NV] = '{
    '{8'hE0,8'h6C,8'h00,2'd2, 1'b1,1'b1,1'b0, 6'd0,6'd0,4'h0, 4'd0,4'd0,8'd0, 3'd0}, // R2 show
    '{8'hE0,8'hF0,8'h6C,2'd3, 1'b1,1'b1,1'b0, 6'd0,6'd0,4'h0, 4'd0,4'd0,8'd0, 3'd0}, // R2 break ignored
    '{8'hE0,8'h72,8'h00,2'd2, 1'b1,1'b1,1'b0, 6'd0,6'd0,4'h0, 4'd0,4'd0,8'd0, 3'd1}, // R4
    '{8'hE0,8'h14,8'h00,2'd2, 1'b1,1'b0,1'b0, 6'd0,6'd0,4'h0, 4'd0,4'd0,8'd0, 3'd1}, // R5 wp off
    '{8'hE0,8'h75,8'h00,2'd2, 1'b1,1'b0,1'b0, 6'd0,6'd0,4'h0, 4'd0,4'd0,8'd0, 3'd0},
    '{8'hE0,8'h75,8'h00,2'd2, 1'b1,1'b0,1'b0, 6'd0,6'd0,4'h0, 4'd0,4'd0,8'd0, 3'd3}, // R4 wrap
    '{8'hE0,8'h14,8'h00,2'd2, 1'b1,1'b0,1'b0, 6'd0,6'd0,4'h0, 4'd0,4'd0,8'd0, 3'd0}, // R6 rom list
    '{8'hE0,8'h75,8'h00,2'd2, 1'b1,1'b0,1'b0, 6'd0,6'd0,4'h0, 4'd0,4'd0,8'd0, 3'd2}, // R6 wrap to 2
    '{8'hE0,8'h14,8'h00,2'd2, 1'b1,1'b0,1'b0, 6'd0,6'd2,4'h0, 4'd0,4'd1,8'd0, 3'd3}, // R7
    '{8'hE0,8'h72,8'h00,2'd2, 1'b1,1'b0,1'b0, 6'd0,6'd2,4'h0, 4'd0,4'd1,8'd0, 3'd0},
    '{8'hE0,8'h14,8'h00,2'd2, 1'b1,1'b0,1'b0, 6'd0,6'd2,4'h0, 4'd0,4'd1,8'd0, 3'd0},
    '{8'hE0,8'h72,8'h00,2'd2, 1'b1,1'b0,1'b0, 6'd0,6'd2,4'h0, 4'd0,4'd1,8'd0, 3'd1},
    '{8'hE0,8'h6B,8'h00,2'd2, 1'b1,1'b0,1'b0, 6'd0,6'd2,4'h0, 4'd0,4'd1,8'd0, 3'd0}, // R8 left
    '{8'hE0,8'h14,8'h00,2'd2, 1'b1,1'b0,1'b0, 6'd0,6'd2,4'h0, 4'd0,4'd1,8'd0, 3'd0},
    '{8'hE0,8'h75,8'h00,2'd2, 1'b1,1'b0,1'b0, 6'd0,6'd2,4'h0, 4'd0,4'd1,8'd0, 3'd0}, // R6 to item 4
    '{8'hE0,8'h14,8'h00,2'd2, 1'b1,1'b0,1'b0, 6'd4,6'd2,4'h0, 4'd1,4'd1,8'd0, 3'd0}, // R7 floppy
    '{8'h1C,8'h00,8'h00,2'd1, 1'b1,1'b0,1'b0, 6'd4,6'd2,4'h0, 4'd1,4'd1,8'd0, 3'd0}, // R9 consumed
    '{8'hE0,8'h72,8'h00,2'd2, 1'b1,1'b0,1'b0, 6'd4,6'd2,4'h0, 4'd1,4'd1,8'd0, 3'd1},
    '{8'hE0,8'h72,8'h00,2'd2, 1'b1,1'b0,1'b0, 6'd4,6'd2,4'h0, 4'd1,4'd1,8'd0, 3'd2},
    '{8'hE0,8'h14,8'h00,2'd2, 1'b1,1'b0,1'b1, 6'd4,6'd2,4'h0, 4'd1,4'd1,8'd0, 3'd2}, // R5 joy on
    '{8'hE0,8'h6C,8'h00,2'd2, 1'b0,1'b0,1'b1, 6'd4,6'd2,4'h0, 4'd1,4'd1,8'd0, 3'd4}, // R2 hide
    '{8'hE0,8'h75,8'h00,2'd2, 1'b0,1'b0,1'b1, 6'd4,6'd2,4'h8, 4'd1,4'd1,8'd0, 3'd4}, // R10
    '{8'hE0,8'h6B,8'h00,2'd2, 1'b0,1'b0,1'b1, 6'd4,6'd2,4'hA, 4'd1,4'd1,8'd0, 3'd4},
    '{8'hE0,8'hF0,8'h75,2'd3, 1'b0,1'b0,1'b1, 6'd4,6'd2,4'h2, 4'd1,4'd1,8'd0, 3'd4},
    '{8'hE0,8'hF0,8'h6B,2'd3, 1'b0,1'b0,1'b1, 6'd4,6'd2,4'h0, 4'd1,4'd1,8'd0, 3'd4},
    '{8'h1C,8'h00,8'h00,2'd1, 1'b0,1'b0,1'b1, 6'd4,6'd2,4'h0, 4'd1,4'd1,8'd1, 3'd4}, // R10 forward
    '{8'hF0,8'h1C,8'h00,2'd2, 1'b0,1'b0,1'b1, 6'd4,6'd2,4'h0, 4'd1,4'd1,8'd2, 3'd4},
    '{8'hE0,8'h6C,8'h00,2'd2, 1'b1,1'b0,1'b1, 6'd4,6'd2,4'h0, 4'd1,4'd1,8'd2, 3'd0},
    '{8'hE0,8'h72,8'h00,2'd2, 1'b1,1'b0,1'b1, 6'd4,6'd2,4'h0, 4'd1,4'd1,8'd2, 3'd1},
    '{8'hE0,8'h72,8'h00,2'd2, 1'b1,1'b0,1'b1, 6'd4,6'd2,4'h0, 4'd1,4'd1,8'd2, 3'd2},
    '{8'hE0,8'h14,8'h00,2'd2, 1'b1,1'b0,1'b0, 6'd4,6'd2,4'h0, 4'd1,4'd1,8'd2, 3'd2},
    '{8'hE0,8'h6C,8'h00,2'd2, 1'b0,1'b0,1'b0, 6'd4,6'd2,4'h0, 4'd1,4'd1,8'd2, 3'd4},
    '{8'hE0,8'h75,8'h00,2'd2, 1'b0,1'b0,1'b0, 6'd4,6'd2,4'h0, 4'd1,4'd1,8'd3, 3'd4}, // R11
    '{8'h6C,8'h00,8'h00,2'd1, 1'b0,1'b0,1'b0, 6'd4,6'd2,4'h0, 4'd1,4'd1,8'd4, 3'd4}  // R3 plain 6C
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(!osd_shown && wp_on && !joy_en, "R1 shown/wp/joy",
        {osd_shown, wp_on, joy_en}, 3'b010);
    chk(floppy_idx == 0 && rom_idx == 0, "R1 indices", {floppy_idx, rom_idx}, 0);
    chk({joy_up, joy_down, joy_left, joy_right} == 4'h0 && !key_valid && !cell_we,
        "R1 idle outputs", {joy_up, joy_down, joy_left, joy_right, key_valid, cell_we}, 0);

    for (int v = 0; v < NV; v++) begin
      put(VEC[v].b0);
      if (VEC[v].nb > 2'd1) put(VEC[v].b1);
      if (VEC[v].nb > 2'd2) put(VEC[v].b2);
      settle();
      chk(osd_shown == VEC[v].sh, $sformatf("R2 vec%0d shown", v), osd_shown, VEC[v].sh);
      chk(wp_on == VEC[v].wp && joy_en == VEC[v].jy, $sformatf("R5 vec%0d flags", v),
          {wp_on, joy_en}, {VEC[v].wp, VEC[v].jy});
      chk(floppy_idx == VEC[v].fi && rom_idx == VEC[v].ri, $sformatf("R7 vec%0d idx", v),
          {floppy_idx, rom_idx}, {VEC[v].fi, VEC[v].ri});
      chk(fs_cnt == int'(VEC[v].fs) && rs_cnt == int'(VEC[v].rs),
          $sformatf("R7 vec%0d strobes", v), fs_cnt * 16 + rs_cnt,
          int'(VEC[v].fs) * 16 + int'(VEC[v].rs));
      chk({joy_up, joy_down, joy_left, joy_right} == VEC[v].dr,
          $sformatf("R10 vec%0d dirs", v), {joy_up, joy_down, joy_left, joy_right}, VEC[v].dr);
      chk(fw_cnt == int'(VEC[v].fw), $sformatf("R9 R11 vec%0d forwards", v),
          fw_cnt, VEC[v].fw);
      if (VEC[v].mr != 3'd4) begin
        for (int r = 0; r < 4; r++) begin
          logic [7:0] e;
          e = (r == int'(VEC[v].mr)) ? ">" : " ";
          chk(shadow[r*COLS] == e, $sformatf("R4 R12 vec%0d row%0d marker", v, r),
              shadow[r*COLS], e);
        end
      end
    end
    // R3 plain 6C forwarded as non-extended make
    chk(last_code == 8'h6C && !last_ext && !last_brk, "R3 plain code fields",
        {last_code, last_ext, last_brk}, {8'h6C, 2'b00});

    // R3 R11: extended release of an arrow, joystick off, overlay hidden
    do_reset();
    put(8'hE0); put(8'hF0); put(8'h75); settle();
    chk(fw_cnt == 1 && last_code == 8'h75 && last_ext && last_brk, "R3 R11 ext break fields",
        {fw_cnt[3:0], last_code, last_ext, last_brk}, {4'd1, 8'h75, 2'b11});

    // R12 top-menu text after showing from reset
    key_ext_make(8'h6C);
    chk(we_cnt == CELLS, "R12 cells per repaint", we_cnt, CELLS);
    chk(shadow[COLS+1] == "W" && shadow[1] == "F" && shadow[3*COLS+1] == "R",
        "R12 labels", {shadow[1], shadow[COLS+1], shadow[3*COLS+1]}, {"F", "W", "R"});
    chk(shadow[COLS+8] == "Y" && shadow[2*COLS+8] == "N", "R12 flag column",
        {shadow[COLS+8], shadow[2*COLS+8]}, {"Y", "N"});

    // R6 R12: floppy list wrapped to item 4 of 5 -> row base 4, rows 1..3 blank
    key_ext_make(8'h14);
    key_ext_make(8'h75);
    chk(shadow[0] == ">" && shadow[1] == "0" && shadow[2] == "4", "R12 list row0",
        {shadow[0], shadow[1], shadow[2]}, {">", "0", "4"});
    chk(shadow[COLS+1] == " " && shadow[COLS+2] == " ", "R12 list blank past count",
        {shadow[COLS+1], shadow[COLS+2]}, {" ", " "});

    // R6 R8: empty ROM list, cursor fixed and confirm ignored, Left returns
    rom_count = '0;
    key_ext_make(8'h6B);
    key_ext_make(8'h75);
    key_ext_make(8'h14);
    key_ext_make(8'h72);
    key_ext_make(8'h14);
    chk(rs_cnt == 0 && rom_idx == 0, "R6 empty list confirm", rs_cnt, 0);
    chk(shadow[0] == ">" && osd_shown, "R6 empty list still open", shadow[0], ">");
    key_ext_make(8'h6B);
    chk(shadow[3*COLS] == ">" && fs_cnt == 0, "R8 back to top entry 3",
        shadow[3*COLS], ">");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule